// File: doc/BRIEF.md
# 64B/66B Receive Block Synchronizer

This block finds block boundaries in a 64B/66B receive stream. A deserializer and gearbox present one 66-bit candidate word per valid cycle. The block checks the two header bits of each word. A legal header always holds a transition, because the header bypasses the scrambler while the payload does not. Header positions that hold no transition show the alignment is wrong. In that case the block raises a one-cycle slip request, and the gearbox shifts its word boundary by one bit.

While unlocked, the block waits for a run of consecutive legal headers and then declares lock. While locked, it tolerates scattered header errors. It drops lock only when too many errors fall inside one fixed window of headers. After every slip, a few words are discarded while the gearbox settles. Every word is passed on one cycle later, together with a flag that says whether its header was legal. Descrambling and decoding are left to later stages.

Top module: `blk_sync`

## Requirements
- R1: The header is rxBlock[1:0]. Values 2'b01 (data) and 2'b10 (control) are legal; 2'b00 and 2'b11 are illegal. hdrValid reports this classification for the word shown on blkOut.
- R2: Every cycle, blkOut and blkValid take the rxBlock and rxValid values of the previous cycle.
- R3: While unlocked and not settling, an illegal header clears the run of legal headers. It also drives slip high for exactly one cycle, in the cycle after that word.
- R4: After each slip, the next 4 valid words are ignored. They are neither counted nor able to cause a slip, whatever their headers.
- R5: While unlocked, 64 consecutive counted legal headers set blockLock, starting in the cycle after the 64th word. An illegal header anywhere in the run prevents lock.
- R6: While locked, the 16th illegal header inside one 64-header window clears blockLock and pulses slip, both in the cycle after that word.
- R7: While locked, the window restarts after every 64 counted headers. A window holding 15 or fewer illegal headers leaves blockLock high.
- R8: Cycles with rxValid low change no counter and raise no slip, whatever rxBlock holds.
- R9: Reset (rstN low, asynchronous) clears blockLock, slip, blkValid and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBlock | input | 66 | Candidate word from the gearbox, header in bits 1:0 |
| rxValid | input | 1 | rxBlock holds a word this cycle |
| slip | output | 1 | One-cycle request to shift the word boundary by one bit |
| blockLock | output | 1 | Block alignment has been found |
| blkOut | output | 66 | Word forwarded one cycle later |
| blkValid | output | 1 | blkOut holds a word |
| hdrValid | output | 1 | Header of blkOut is 01 or 10 |

## Verification
Every result of this block is due exactly one clock edge after the word that causes it. This holds for the forwarded word and its header flag, and also for the slip pulse and each blockLock change. No later cycle ever carries a reaction to an earlier word. The bench drives each word at a falling edge. At the next falling edge it compares all outputs with a behavioural model that was advanced by that same word, so each comparison covers one edge only. Runs are sized to exact window and lock boundaries, so the edges where lock is won, kept and lost all land on known cycles.

// File: rtl/blk_sync_pkg.sv
package blk_sync_pkg;
  // header classification handed from datapath to control
  typedef struct packed {
    logic present;
    logic hdrOk;
  } hdrInfo_t;

  // registered decisions handed from control back to datapath
  typedef struct packed {
    logic slip;
    logic lock;
  } syncStrobe_t;
endpackage

// File: rtl/blk_sync_datapath.sv
module blk_sync_datapath
  import blk_sync_pkg::*;
#(
  parameter int BLOCK_W = 66,
  parameter int HDR_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BLOCK_W-1:0] rxBlock,
  input  logic               rxValid,
  input  syncStrobe_t        strobe,
  output hdrInfo_t           hdr,
  output logic [BLOCK_W-1:0] blkOut,
  output logic               blkValid,
  output logic               hdrValid,
  output logic               slip,
  output logic               blockLock
);
  localparam logic [HDR_W-1:0] HDR_ZERO = '0;
  localparam logic [HDR_W-1:0] HDR_ONES = '1;

  logic [HDR_W-1:0] hdrField;
  logic             hdrLegal;

  // a legal header is one that carries a transition
  assign hdrField = rxBlock[HDR_W-1:0];
  assign hdrLegal = (hdrField != HDR_ZERO) && (hdrField != HDR_ONES);

  assign hdr.present = rxValid;
  assign hdr.hdrOk   = hdrLegal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkOut   <= '0;
      blkValid <= 1'b0;
      hdrValid <= 1'b0;
    end else begin
      blkOut   <= rxBlock;
      blkValid <= rxValid;
      hdrValid <= hdrLegal;
    end
  end

  assign slip      = strobe.slip;
  assign blockLock = strobe.lock;

  // R2: word forwarded one cycle later
  assert_forward_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (blkValid && blkOut == $past(rxBlock)));

  // R8: no valid input means no valid output next cycle
  assert_idle_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !blkValid);
endmodule

// File: rtl/blk_sync_ctrl.sv
module blk_sync_ctrl
  import blk_sync_pkg::*;
#(
  parameter int LOCK_CNT    = 64,
  parameter int WIN_LEN     = 64,
  parameter int BAD_LIM     = 16,
  parameter int SETTLE_BLKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  hdrInfo_t    hdr,
  output syncStrobe_t strobe
);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int BW = $clog2(BAD_LIM + 1);
  localparam int SW = $clog2(SETTLE_BLKS + 1);
  localparam logic [GW-1:0] GOOD_LAST   = GW'(LOCK_CNT - 1);
  localparam logic [WW-1:0] WIN_LAST    = WW'(WIN_LEN - 1);
  localparam logic [BW-1:0] BAD_LAST    = BW'(BAD_LIM - 1);
  localparam logic [SW-1:0] SETTLE_INIT = SW'(SETTLE_BLKS);

  logic [GW-1:0] goodCnt, goodN;
  logic [WW-1:0] winCnt, winN;
  logic [BW-1:0] badCnt, badN;
  logic [SW-1:0] settleCnt, settleN;
  logic          lockQ, lockN, slipQ, slipN;

  always_comb begin
    goodN   = goodCnt;
    winN    = winCnt;
    badN    = badCnt;
    settleN = settleCnt;
    lockN   = lockQ;
    slipN   = 1'b0;
    if (hdr.present) begin
      if (settleCnt != '0) begin
        settleN = settleCnt - 1'b1;
      end else if (!lockQ) begin
        if (hdr.hdrOk) begin
          if (goodCnt == GOOD_LAST) begin
            lockN = 1'b1;
            goodN = '0;
            winN  = '0;
            badN  = '0;
          end else begin
            goodN = goodCnt + 1'b1;
          end
        end else begin
          goodN   = '0;
          slipN   = 1'b1;
          settleN = SETTLE_INIT;
        end
      end else begin
        if (!hdr.hdrOk && badCnt == BAD_LAST) begin
          lockN   = 1'b0;
          slipN   = 1'b1;
          settleN = SETTLE_INIT;
          goodN   = '0;
          winN    = '0;
          badN    = '0;
        end else begin
          if (!hdr.hdrOk) badN = badCnt + 1'b1;
          if (winCnt == WIN_LAST) begin
            winN = '0;
            badN = '0;
          end else begin
            winN = winCnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt   <= '0;
      winCnt    <= '0;
      badCnt    <= '0;
      settleCnt <= '0;
      lockQ     <= 1'b0;
      slipQ     <= 1'b0;
    end else begin
      goodCnt   <= goodN;
      winCnt    <= winN;
      badCnt    <= badN;
      settleCnt <= settleN;
      lockQ     <= lockN;
      slipQ     <= slipN;
    end
  end

  assign strobe.slip = slipQ;
  assign strobe.lock = lockQ;

  // R3: slip never lasts longer than one cycle
  assert_slip_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    slipQ |=> !slipQ);

  // R4: settling only happens while unlocked
  assert_settle_unlocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt != '0) |-> !lockQ);

  // R5: lock only follows a full run of legal headers
  assert_lock_after_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> ($past(goodCnt) == GOOD_LAST && $past(hdr.hdrOk)));

  // R6: losing lock always comes with a slip
  assert_drop_slips_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> slipQ);

  // R6: the error count never reaches the limit as stored state
  assert_bad_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    badCnt <= BAD_LAST);

  // R8: idle cycles change no decision state
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hdr.present |=> ($stable(goodCnt) && $stable(lockQ) && !slipQ));
endmodule

// File: rtl/blk_sync.sv
module blk_sync
  import blk_sync_pkg::*;
#(
  parameter int BLOCK_W     = 66,
  parameter int HDR_W       = 2,
  parameter int LOCK_CNT    = 64,
  parameter int WIN_LEN     = 64,
  parameter int BAD_LIM     = 16,
  parameter int SETTLE_BLKS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BLOCK_W-1:0] rxBlock,
  input  logic               rxValid,
  output logic               slip,
  output logic               blockLock,
  output logic [BLOCK_W-1:0] blkOut,
  output logic               blkValid,
  output logic               hdrValid
);
  hdrInfo_t    hdr;
  syncStrobe_t strobe;

  blk_sync_datapath #(
    .BLOCK_W(BLOCK_W),
    .HDR_W  (HDR_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .rxBlock  (rxBlock),
    .rxValid  (rxValid),
    .strobe   (strobe),
    .hdr      (hdr),
    .blkOut   (blkOut),
    .blkValid (blkValid),
    .hdrValid (hdrValid),
    .slip     (slip),
    .blockLock(blockLock)
  );

  blk_sync_ctrl #(
    .LOCK_CNT   (LOCK_CNT),
    .WIN_LEN    (WIN_LEN),
    .BAD_LIM    (BAD_LIM),
    .SETTLE_BLKS(SETTLE_BLKS)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .hdr   (hdr),
    .strobe(strobe)
  );
endmodule

// File: tb/test_blk_sync.sv
`timescale 1ns/1ps
module test_blk_sync;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [65:0] rxBlock = '0;
  logic        rxValid = 1'b0;
  logic        slip, blockLock, blkValid, hdrValid;
  logic [65:0] blkOut;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int   mGood, mWin, mBad, mSettle;
  bit   mLock;
  bit   eSlip, eLock, eBV, eHV;
  logic [65:0] eBlk;
  string tag = "R9";

  always #2.5 clk = ~clk;

  blk_sync i_blk_sync (
    .clk(clk), .rstN(rstN), .rxBlock(rxBlock), .rxValid(rxValid),
    .slip(slip), .blockLock(blockLock), .blkOut(blkOut),
    .blkValid(blkValid), .hdrValid(hdrValid)
  );

  task automatic chk(input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(tag, "slip", {65'd0, slip}, {65'd0, eSlip});
    chk(tag, "blockLock", {65'd0, blockLock}, {65'd0, eLock});
    chk("R2", "blkValid", {65'd0, blkValid}, {65'd0, eBV});
    if (eBV) begin
      chk("R1", "hdrValid", {65'd0, hdrValid}, {65'd0, eHV});
      chk("R2", "blkOut", blkOut, eBlk);
    end
  endtask

  task automatic modelReset();
    mGood = 0; mWin = 0; mBad = 0; mSettle = 0; mLock = 0;
    eSlip = 0; eLock = 0; eBV = 0; eHV = 0; eBlk = '0;
  endtask

  task automatic modelStep(input bit v, input logic [65:0] b);
    bit ok;
    ok = (b[1:0] == 2'b01) || (b[1:0] == 2'b10);
    eBV = v; eBlk = b; eHV = ok; eSlip = 0;
    if (v) begin
      if (mSettle > 0) mSettle--;
      else if (!mLock) begin
        if (ok) begin
          mGood++;
          if (mGood == 64) begin mLock = 1; mGood = 0; mWin = 0; mBad = 0; end
        end else begin
          mGood = 0; eSlip = 1; mSettle = 4;
        end
      end else begin
        mWin++;
        if (!ok) mBad++;
        if (mBad == 16) begin
          mLock = 0; eSlip = 1; mSettle = 4; mWin = 0; mBad = 0; mGood = 0;
        end else if (mWin == 64) begin
          mWin = 0; mBad = 0;
        end
      end
    end
    eLock = mLock;
  endtask

  function automatic logic [1:0] goodH();
    return ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] badH();
    return ($urandom_range(0, 1) != 0) ? 2'b00 : 2'b11;
  endfunction

  // called at a falling edge: check previous edge, drive next word
  task automatic step(input bit v, input logic [1:0] h);
    logic [65:0] b;
    b = {32'($urandom()), 32'($urandom()), h};
    compareAll();
    rxValid = v;
    rxBlock = b;
    modelStep(v, b);
    @(negedge clk);
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) step(1'b1, goodH());
  endtask

  task automatic bads(input int n);
    for (int i = 0; i < n; i++) step(1'b1, badH());
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rxValid = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    tag = "R9";
    compareAll();
    rstN = 1'b1;
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();                          // R9 reset state
    step(1'b0, 2'b00);
    step(1'b0, 2'b11);

    tag = "R3";                         // unlocked slip on illegal header
    goods(10);
    bads(1);

    tag = "R4";                         // settle: illegal headers ignored
    bads(4);
    bads(1);                            // counted again: slips
    goods(4);                           // settle words, not counted

    tag = "R8";                         // idle cycles carry garbage
    for (int i = 0; i < 5; i++) step(1'b0, badH());

    tag = "R5";                         // broken run, then full run
    goods(63);
    bads(1);
    goods(4);
    goods(64);
    goods(1);

    tag = "R7";                         // 15 errors per window keep lock
    goods(48);
    bads(15);
    for (int w = 0; w < 2; w++) begin
      goods(49);
      bads(15);
    end
    goods(3);

    tag = "R6";                         // 16th error in a window drops lock
    bads(16);
    goods(6);

    tag = "R5";                         // relock
    goods(64);
    goods(2);

    doReset();                          // R9 reset while locked
    step(1'b0, 2'b01);
    step(1'b0, 2'b01);
    compareAll();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule